// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division on two operands and keeps its results in a dedicated pair of result registers, HI and LO. A multiply puts the full double-width product across the pair, with the upper half in HI and the lower half in LO. A divide puts the quotient in LO and the remainder in HI. Both operations come in signed (two's complement) and unsigned forms. The pair is read and written only through four move commands.

Multiplication finishes in the cycle it is issued. Division is iterative: one quotient bit per cycle, with a busy flag raised for the whole loop. A zero divisor is caught before the loop starts. A signed multiply whose product does not fit in LO is reported on an overflow flag.

The unit is driven one command per cycle. A result or flag appears on the clock edge that completes the command. Move-from data is returned combinationally while the command is presented.

Top module: `muldiv_hilo`

## Requirements
- R1: Opcode 0 (signed multiply) writes the low half of the signed product of opa and opb into LO and the high half into HI on the accepting edge.
- R2: Opcode 1 (unsigned multiply) writes the unsigned product in the same way: low half to LO, high half to HI.
- R3: After an accepted opcode 0, mul_ovf_o is high for exactly one cycle when the new HI is not the sign-extension of bit XLEN-1 of the new LO. It never rises for opcode 1.
- R4: Opcode 3 (unsigned divide) writes the quotient opa/opb into LO and the remainder into HI.
- R5: Opcode 2 (signed divide) divides the magnitudes. The quotient is negative when the operand signs differ, and the remainder takes the dividend's sign.
- R6: A divide with opb equal to zero does not start the loop and leaves HI and LO unchanged. div_zero_o is high for exactly the one cycle after the accepting edge.
- R7: busy_o rises on the edge that accepts a non-zero divide and stays high for XLEN cycles. HI and LO take the result on the edge where busy_o falls.
- R8: While busy_o is high, every command is ignored: multiply, divide, move-to HI (opcode 6) and move-to LO (opcode 7) change neither HI nor LO.
- R9: A move-from HI (opcode 4) or move-from LO (opcode 5) issued while busy returns the old register contents on rdata_o and raises stall_o in the same cycle.
- R10: Reset clears HI and LO to zero. Opcodes 6 and 7 write opa into HI and LO respectively. Move-from returns the register on rdata_o in the cycle the command is presented, and rdata_o is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Opcode 0..7 as listed in the requirements |
| opa_i | input | XLEN | First operand / dividend / move-to data |
| opb_i | input | XLEN | Second operand / divisor |
| rdata_o | output | XLEN | Move-from result |
| stall_o | output | 1 | Move-from issued while a divide runs |
| busy_o | output | 1 | Divide loop in progress |
| div_zero_o | output | 1 | One-cycle pulse after a divide by zero |
| mul_ovf_o | output | 1 | One-cycle pulse after an overflowing signed multiply |

## Verification
The bench uses the default XLEN of 32, so the cases are full-width corner values. These include an all-ones unsigned square, a product that lands exactly on bit 31 of LO, and signed divides in all three sign combinations. With this width the busy window is counted cycle by cycle against the full 32 iterations. Moves issued in the middle of the loop test the ignore rule and the stall rule while HI and LO still hold the values from before the divide.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_MULU = 3'd1,
    OP_DIV  = 3'd2,
    OP_DIVU = 3'd3,
    OP_MFHI = 3'd4,
    OP_MFLO = 3'd5,
    OP_MTHI = 3'd6,
    OP_MTLO = 3'd7
  } md_op_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic              signed_i,
  output logic [2*XLEN-1:0] prod_o,
  output logic              ovf_o
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0] a_ext, b_ext;

  always_comb begin
    a_ext  = {{XLEN{signed_i & a_i[XLEN-1]}}, a_i};
    b_ext  = {{XLEN{signed_i & b_i[XLEN-1]}}, b_i};
    prod_o = a_ext * b_ext;  // truncated double-width product is exact for both forms
    ovf_o  = signed_i && (prod_o[PW-1:XLEN] != {XLEN{prod_o[XLEN-1]}});
  end
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            signed_i,
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic            busy_o,
  output logic            last_o,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);
  localparam int CW = $clog2(XLEN + 1);

  logic [XLEN-1:0] quo_q, rem_q, dvs_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, neg_quo_q, neg_rem_q;

  logic [XLEN-1:0] dvd_mag, dvs_mag, quo_n, rem_n;
  logic [XLEN:0]   shifted, diff;

  always_comb begin
    dvd_mag = (signed_i && dvd_i[XLEN-1]) ? -dvd_i : dvd_i;
    dvs_mag = (signed_i && dvs_i[XLEN-1]) ? -dvs_i : dvs_i;
    shifted = {rem_q, quo_q[XLEN-1]};
    diff    = shifted - {1'b0, dvs_q};
    if (!diff[XLEN]) begin
      rem_n = diff[XLEN-1:0];
      quo_n = {quo_q[XLEN-2:0], 1'b1};
    end else begin
      rem_n = shifted[XLEN-1:0];
      quo_n = {quo_q[XLEN-2:0], 1'b0};
    end
    quo_o  = neg_quo_q ? -quo_n : quo_n;
    rem_o  = neg_rem_q ? -rem_n : rem_n;
    last_o = busy_q && (cnt_q == CW'(1));
    busy_o = busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q     <= '0;
      rem_q     <= '0;
      dvs_q     <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      quo_q     <= dvd_mag;
      rem_q     <= '0;
      dvs_q     <= dvs_mag;
      cnt_q     <= CW'(XLEN);
      busy_q    <= 1'b1;
      neg_quo_q <= signed_i && (dvd_i[XLEN-1] ^ dvs_i[XLEN-1]);
      neg_rem_q <= signed_i && dvd_i[XLEN-1];
    end else if (busy_q) begin
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      cnt_q  <= cnt_q - CW'(1);
      busy_q <= (cnt_q != CW'(1));
    end
  end

  p_busy_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0));
  p_start_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && cnt_q == CW'(XLEN)));
  p_last_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_q);
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            stall_o,
  output logic            busy_o,
  output logic            div_zero_o,
  output logic            mul_ovf_o
);
  import muldiv_pkg::*;

  md_op_e              op;
  logic                acc, is_mul, is_div, dz_hit, div_start, is_mf;
  logic [2*XLEN-1:0]   prod;
  logic                prod_ovf, div_busy, div_last;
  logic [XLEN-1:0]     div_quo, div_rem;
  logic [XLEN-1:0]     hi_q, lo_q;
  logic                dz_q, ovf_q;

  always_comb begin
    op        = md_op_e'(cmd_op_i);
    acc       = cmd_valid_i && !div_busy;
    is_mul    = acc && (op == OP_MUL || op == OP_MULU);
    is_div    = acc && (op == OP_DIV || op == OP_DIVU);
    dz_hit    = is_div && (opb_i == '0);
    div_start = is_div && (opb_i != '0);
    is_mf     = cmd_valid_i && (op == OP_MFHI || op == OP_MFLO);
  end

  muldiv_mul #(.XLEN(XLEN)) i_mul (
    .a_i      (opa_i),
    .b_i      (opb_i),
    .signed_i (op == OP_MUL),
    .prod_o   (prod),
    .ovf_o    (prod_ovf)
  );

  muldiv_div #(.XLEN(XLEN)) i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (div_start),
    .signed_i (op == OP_DIV),
    .dvd_i    (opa_i),
    .dvs_i    (opb_i),
    .busy_o   (div_busy),
    .last_o   (div_last),
    .quo_o    (div_quo),
    .rem_o    (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dz_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      dz_q  <= dz_hit;
      ovf_q <= is_mul && prod_ovf;
      if (div_last) begin
        hi_q <= div_rem;
        lo_q <= div_quo;
      end else if (is_mul) begin
        hi_q <= prod[2*XLEN-1:XLEN];
        lo_q <= prod[XLEN-1:0];
      end else if (acc && op == OP_MTHI) begin
        hi_q <= opa_i;
      end else if (acc && op == OP_MTLO) begin
        lo_q <= opa_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (cmd_valid_i && op == OP_MFHI) rdata_o = hi_q;
    else if (cmd_valid_i && op == OP_MFLO) rdata_o = lo_q;
    stall_o    = is_mf && div_busy;
    busy_o     = div_busy;
    div_zero_o = dz_q;
    mul_ovf_o  = ovf_q;
  end

  p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_busy && !div_last) |=> ($stable(hi_q) && $stable(lo_q)));
  p_dz_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> ($stable(hi_q) && $stable(lo_q) && !busy_o));
  p_dz_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_zero_o && !(cmd_valid_i && cmd_op_i == 3'd2) && !(cmd_valid_i && cmd_op_i == 3'd3)) |=> !div_zero_o);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_ovf_o |-> $past(cmd_valid_i && cmd_op_i == 3'd0));
  p_ovf_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_ovf_o |-> (hi_q != {XLEN{lo_q[XLEN-1]}}));
endmodule

// File: tb/test_muldiv_hilo.sv
module test_muldiv_hilo;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cmd_valid_i = 1'b0;
  logic [2:0]      cmd_op_i = '0;
  logic [XLEN-1:0] opa_i = '0, opb_i = '0;
  logic [XLEN-1:0] rdata_o;
  logic            stall_o, busy_o, div_zero_o, mul_ovf_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  muldiv_hilo #(.XLEN(XLEN)) i_muldiv_hilo (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .opa_i(opa_i), .opb_i(opb_i), .rdata_o(rdata_o), .stall_o(stall_o),
    .busy_o(busy_o), .div_zero_o(div_zero_o), .mul_ovf_o(mul_ovf_o)
  );

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle command, returns with inputs idle at a negedge after the accepting edge
  task automatic issue(logic [2:0] op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic read_reg(logic [2:0] op, output logic [XLEN-1:0] val, output logic stl);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op;
    #2;
    val = rdata_o; stl = stall_o;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic expect_hilo(string req, logic [XLEN-1:0] hi, logic [XLEN-1:0] lo);
    logic [XLEN-1:0] v; logic s;
    read_reg(3'd4, v, s); check(req, v, hi);
    read_reg(3'd5, v, s); check(req, v, lo);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    check("R10 reset busy", {31'b0, busy_o}, 0);
    check("R6 reset dz", {31'b0, div_zero_o}, 0);
    check("R3 reset ovf", {31'b0, mul_ovf_o}, 0);
    check("R10 idle rdata", rdata_o, 0);
    expect_hilo("R10 reset hilo", 0, 0);
  endtask

  task automatic t_moves;
    issue(3'd6, 32'hCAFE0001, 0);
    issue(3'd7, 32'h0BAD0002, 0);
    expect_hilo("R10 move-to", 32'hCAFE0001, 32'h0BAD0002);
  endtask

  task automatic t_mul;
    issue(3'd0, -32'sd5, 32'd7);
    check("R3 no ovf small", {31'b0, mul_ovf_o}, 0);
    expect_hilo("R1 signed -5*7", 32'hFFFFFFFF, 32'hFFFFFFDD);
    issue(3'd0, 32'h00010000, 32'h00010000);
    check("R3 ovf 2^32", {31'b0, mul_ovf_o}, 1);
    @(negedge clk);
    check("R3 ovf pulse ends", {31'b0, mul_ovf_o}, 0);
    expect_hilo("R1 signed 2^32", 32'h1, 32'h0);
    issue(3'd0, 32'h40000000, 32'd2);
    check("R3 ovf into sign bit", {31'b0, mul_ovf_o}, 1);
    expect_hilo("R1 signed 2^31", 32'h0, 32'h80000000);
    issue(3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R3 unsigned no ovf", {31'b0, mul_ovf_o}, 0);
    expect_hilo("R2 unsigned max^2", 32'hFFFFFFFE, 32'h00000001);
  endtask

  task automatic t_divu;
    int n;
    issue(3'd3, 32'd100, 32'd7);
    check("R7 busy after start", {31'b0, busy_o}, 1);
    wait_idle(n);
    check("R7 busy length", n, XLEN);
    expect_hilo("R4 100/7", 32'd2, 32'd14);
    issue(3'd3, 32'hFFFFFFFF, 32'd2);
    wait_idle(n);
    expect_hilo("R4 max/2", 32'd1, 32'h7FFFFFFF);
  endtask

  task automatic t_divs;
    int n;
    issue(3'd2, -32'sd7, 32'd2);  wait_idle(n);
    expect_hilo("R5 -7/2", 32'hFFFFFFFF, 32'hFFFFFFFD);
    issue(3'd2, 32'd7, -32'sd2);  wait_idle(n);
    expect_hilo("R5 7/-2", 32'd1, 32'hFFFFFFFD);
    issue(3'd2, -32'sd7, -32'sd2); wait_idle(n);
    expect_hilo("R5 -7/-2", 32'hFFFFFFFF, 32'd3);
  endtask

  task automatic t_divzero;
    issue(3'd6, 32'h11112222, 0);
    issue(3'd7, 32'h33334444, 0);
    issue(3'd3, 32'd5, 32'd0);
    check("R6 dz pulse", {31'b0, div_zero_o}, 1);
    check("R6 no busy", {31'b0, busy_o}, 0);
    @(negedge clk);
    check("R6 dz one cycle", {31'b0, div_zero_o}, 0);
    expect_hilo("R6 hilo kept", 32'h11112222, 32'h33334444);
  endtask

  task automatic t_busy;
    int n; logic [XLEN-1:0] v; logic s;
    issue(3'd6, 32'hAAAA0000, 0);
    issue(3'd7, 32'h5555FFFF, 0);
    issue(3'd3, 32'd50, 32'd8);
    issue(3'd6, 32'h12345678, 0);
    issue(3'd7, 32'h87654321, 0);
    issue(3'd1, 32'd3, 32'd3);
    read_reg(3'd4, v, s);
    check("R9 old HI while busy", v, 32'hAAAA0000);
    check("R9 stall HI", {31'b0, s}, 1);
    read_reg(3'd5, v, s);
    check("R9 old LO while busy", v, 32'h5555FFFF);
    check("R9 stall LO", {31'b0, s}, 1);
    wait_idle(n);
    check("R8 busy length with traffic", n, XLEN - 10);
    read_reg(3'd4, v, s);
    check("R9 no stall idle", {31'b0, s}, 0);
    check("R8 HI is remainder", v, 32'd2);
    read_reg(3'd5, v, s);
    check("R8 LO is quotient", v, 32'd6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_moves();
    t_mul();
    t_divu();
    t_divs();
    t_divzero();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule